// File: doc/BRIEF.md
# Key-Protected Independent Watchdog

This block is a watchdog timer that counts down on its own slow clock. A power-of-two prescaler sets how often the counter steps, and a reload register sets the starting count. If software lets the count run out, the block raises a reset request for one clock. Here the slow clock is the only clock, so the bus writes are sampled on that same clock.

Software uses three write-only registers. Magic values written to the key register start the timer, refresh it, and open or close write access to the two configuration registers. Once started, the timer cannot be stopped by any write. Only a system reset stops it.

Top module: `keyed_wdg`

## Requirements
- R1: After reset the timer is stopped and write access is locked. The prescaler field is 0, giving divide-by-4, and the reload value is 0x7FF. A start with no configuration writes therefore expires after 8188 clocks.
- R2: Writing 0xCCCC to the key register (wr_sel = 0) starts the timer. The counter is loaded with the reload value and the prescaler phase is cleared.
- R3: Writing 0xAAAA to the key register reloads the counter and clears the prescaler phase. A full period then starts again, and no request is raised in the cycle after the write.
- R4: Writing 0x5555 to the key register opens write access. While it is open, writes at wr_sel = 1 set the prescaler from wr_data[2:0] and writes at wr_sel = 2 set the reload from wr_data[10:0]. All higher bits are dropped.
- R5: Any key write other than 0x5555 closes write access. While access is closed, writes to the prescaler and reload registers have no effect.
- R6: The prescaler divides by 2^(field+2), from 4 up to 512.
- R7: A period lasts max(reload,1) × division clocks, counted from a start or refresh. At its end wdg_reset_req is high for exactly one clock, and the counter reloads for the next period.
- R8: Once started, the timer keeps running through every kind of write until reset.
- R9: A key write with an undefined value leaves the counter and the prescaler phase untouched.
- R10: While the timer is stopped, wdg_reset_req stays low, even after a refresh key.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Slow watchdog clock, which also samples writes |
| rst_n | input | 1 | Active-low system reset |
| wr_en | input | 1 | Write strobe, one write per clock |
| wr_sel | input | 2 | Register select: 0 key, 1 prescaler, 2 reload, 3 unused |
| wr_data | input | 16 | Write data |
| wdg_reset_req | output | 1 | One-clock reset request at the end of a period |

## Verification
The hardest conditions to reach are the ones that depend on the irreversible start. The default configuration can be observed only once per reset, and a stopped timer can be observed only before the first start. The bench therefore resets the block between phases: one phase exercises the stopped state and the refresh key, and another starts the timer after config writes made while access was locked. Lock state is only visible through the period it produces. So each config attempt is followed by a refresh, and the period measured at the port is compared with the value the bench computes. Random values with junk upper bits exercise the field masking.

// File: rtl/keyed_wdg_pkg.sv
package keyed_wdg_pkg;
  localparam int KEY_W = 16;

  localparam logic [KEY_W-1:0] KEY_REFRESH = 16'hAAAA;
  localparam logic [KEY_W-1:0] KEY_UNLOCK  = 16'h5555;
  localparam logic [KEY_W-1:0] KEY_START   = 16'hCCCC;

  localparam logic [1:0] SEL_KEY    = 2'd0;
  localparam logic [1:0] SEL_PRESC  = 2'd1;
  localparam logic [1:0] SEL_RELOAD = 2'd2;

  typedef enum logic [1:0] {
    CMD_OTHER,
    CMD_REFRESH,
    CMD_UNLOCK,
    CMD_START
  } key_cmd_e;

  function automatic key_cmd_e decode_key(input logic [KEY_W-1:0] v);
    key_cmd_e c;
    c = CMD_OTHER;
    if (v == KEY_REFRESH) c = CMD_REFRESH;
    if (v == KEY_UNLOCK)  c = CMD_UNLOCK;
    if (v == KEY_START)   c = CMD_START;
    return c;
  endfunction

  // Division ratio of the prescaler: 2^(field+2).
  function automatic int unsigned div_ratio(input int unsigned field);
    return 32'd1 << (field + 2);
  endfunction
endpackage

// File: rtl/keyed_wdg_regs.sv
module keyed_wdg_regs
  import keyed_wdg_pkg::*;
#(
  parameter int PRE_W = 3,
  parameter int RLD_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       wr_sel,
  input  logic [KEY_W-1:0] wr_data,
  output logic [PRE_W-1:0] presc_o,
  output logic [RLD_W-1:0] reload_o,
  output logic             running_o,
  output logic             load_o
);
  logic     unlocked_q;
  logic     key_write;
  logic     cfg_presc_wr;
  logic     cfg_reload_wr;
  key_cmd_e cmd;

  assign key_write     = wr_en && (wr_sel == SEL_KEY);
  assign cmd           = decode_key(wr_data);
  assign cfg_presc_wr  = wr_en && unlocked_q && (wr_sel == SEL_PRESC);
  assign cfg_reload_wr = wr_en && unlocked_q && (wr_sel == SEL_RELOAD);
  assign load_o        = key_write && (cmd == CMD_REFRESH || cmd == CMD_START);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      unlocked_q <= 1'b0;
      running_o  <= 1'b0;
      presc_o    <= '0;
      reload_o   <= '1;
    end else begin
      if (key_write) begin
        unlocked_q <= (cmd == CMD_UNLOCK);
        if (cmd == CMD_START) running_o <= 1'b1;
      end
      if (cfg_presc_wr)  presc_o  <= wr_data[PRE_W-1:0];
      if (cfg_reload_wr) reload_o <= wr_data[RLD_W-1:0];
    end
  end

  assert_locked_cfg_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !unlocked_q |=> ($stable(presc_o) && $stable(reload_o)));

  assert_unlock_by_key_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(unlocked_q) |-> $past(key_write && wr_data == KEY_UNLOCK));

  assert_never_stops_R8: assert property (@(posedge clk) disable iff (!rst_n)
    running_o |=> running_o);
endmodule

// File: rtl/keyed_wdg_prescaler.sv
module keyed_wdg_prescaler
  import keyed_wdg_pkg::*;
#(
  parameter int PRE_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic             clear_i,
  input  logic [PRE_W-1:0] presc_i,
  output logic             tick_o
);
  // Largest exponent is (2^PRE_W - 1) + 2, so the phase needs that many bits.
  localparam int PCNT_W = (1 << PRE_W) + 1;

  logic [PCNT_W-1:0] phase_q;
  logic [PCNT_W-1:0] last_phase;

  function automatic logic [PCNT_W-1:0] terminal(input logic [PRE_W-1:0] f);
    return PCNT_W'(div_ratio(int'(f)) - 1);
  endfunction

  assign last_phase = terminal(presc_i);
  // >= keeps a shrinking prescaler from skipping its terminal count.
  assign tick_o     = run_i && !clear_i && (phase_q >= last_phase);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   phase_q <= '0;
    else if (clear_i || !run_i)   phase_q <= '0;
    else if (tick_o)              phase_q <= '0;
    else                          phase_q <= phase_q + PCNT_W'(1);
  end

  assert_tick_needs_run_R10: assert property (@(posedge clk) disable iff (!rst_n)
    tick_o |-> run_i);

  assert_tick_spacing_R6: assert property (@(posedge clk) disable iff (!rst_n)
    tick_o |=> !tick_o);
endmodule

// File: rtl/keyed_wdg_counter.sv
module keyed_wdg_counter #(
  parameter int RLD_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic             tick_i,
  input  logic [RLD_W-1:0] reload_i,
  output logic             expire_o,
  output logic             req_o
);
  logic [RLD_W-1:0] count_q;

  // Load wins over expiry. A count of 0 or 1 ends the period on this tick.
  assign expire_o = tick_i && !load_i && (count_q <= RLD_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '1;
      req_o   <= 1'b0;
    end else begin
      req_o <= expire_o;
      if (load_i || expire_o) count_q <= reload_i;
      else if (tick_i)        count_q <= count_q - RLD_W'(1);
    end
  end

  assert_req_one_cycle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    req_o |=> !req_o);

  assert_refresh_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> !req_o);
endmodule

// File: rtl/keyed_wdg.sv
module keyed_wdg
  import keyed_wdg_pkg::*;
#(
  parameter int PRE_W = 3,
  parameter int RLD_W = 11
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [1:0]  wr_sel,
  input  logic [15:0] wr_data,
  output logic        wdg_reset_req
);
  logic [PRE_W-1:0] presc;
  logic [RLD_W-1:0] reload;
  logic             running;
  logic             load_evt;
  logic             tick_evt;
  logic             expire_evt;

  keyed_wdg_regs #(.PRE_W(PRE_W), .RLD_W(RLD_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .presc_o(presc), .reload_o(reload), .running_o(running), .load_o(load_evt)
  );

  keyed_wdg_prescaler #(.PRE_W(PRE_W)) u_presc (
    .clk(clk), .rst_n(rst_n), .run_i(running), .clear_i(load_evt),
    .presc_i(presc), .tick_o(tick_evt)
  );

  keyed_wdg_counter #(.RLD_W(RLD_W)) u_count (
    .clk(clk), .rst_n(rst_n), .load_i(load_evt), .tick_i(tick_evt),
    .reload_i(reload), .expire_o(expire_evt), .req_o(wdg_reset_req)
  );

  assert_stopped_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !running |-> !wdg_reset_req);

  assert_start_runs_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == SEL_KEY && wr_data == KEY_START) |=> running);

  assert_expire_to_req_R7: assert property (@(posedge clk) disable iff (!rst_n)
    expire_evt |=> wdg_reset_req);
endmodule

// File: tb/test_keyed_wdg.sv
module test_keyed_wdg;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = 2'd0;
  logic [15:0] wr_data = 16'd0;
  logic        wdg_reset_req;

  int tests = 0;
  int fails = 0;
  localparam int LIMIT = 20000;

  always #5 clk = ~clk;

  keyed_wdg i_keyed_wdg (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .wdg_reset_req(wdg_reset_req)
  );

  function automatic int period_of(input int p, input int r);
    int d;
    d = 4;
    for (int k = 0; k < p; k++) d = d * 2;
    return (r == 0 ? 1 : r) * d;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [1:0] sel, input logic [15:0] data);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = data;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wait_req(inout int n);
    while (!wdg_reset_req && n < LIMIT) begin
      @(negedge clk);
      n++;
    end
  endtask

  // After a refresh: two periods with a one-clock pulse between them.
  task automatic measure_two(input string req, input int exp);
    int n1;
    int n2;
    n1 = 0;
    wait_req(n1);
    check(req, n1, exp);
    @(negedge clk);
    check("R7 pulse width", int'(wdg_reset_req), 0);
    n2 = 1;
    wait_req(n2);
    check("R7 periodic", n2, exp);
  endtask

  task automatic configure(input logic [15:0] pd, input logic [15:0] rd);
    bus_write(2'd0, 16'h5555);
    bus_write(2'd1, pd);
    bus_write(2'd2, rd);
    bus_write(2'd0, 16'hAAAA);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int n;
    int seen;
    int unsigned seed;
    seed = $urandom(32'd9127);

    // Phase A: stopped timer.
    do_reset();
    check("R1 reset output", int'(wdg_reset_req), 0);
    configure(16'h0000, 16'h0001);   // would be 4 clocks if running
    seen = 0;
    for (int k = 0; k < 100; k++) begin
      @(negedge clk);
      if (wdg_reset_req) seen++;
    end
    check("R10 no request while stopped", seen, 0);

    // Phase B: locked writes ignored, default period.
    do_reset();
    bus_write(2'd1, 16'h0001);
    bus_write(2'd2, 16'h0005);
    bus_write(2'd0, 16'hCCCC);
    n = 0;
    wait_req(n);
    check("R1 R2 R5 default period", n, 8188);
    @(negedge clk);
    check("R7 pulse width default", int'(wdg_reset_req), 0);

    // Masked fields: presc 2 (div 16), reload 10.
    configure(16'hFFFA, 16'hF80A);
    measure_two("R3 R4 R6 masked fields", 160);

    // Undefined key re-locks; reload write then ignored.
    bus_write(2'd0, 16'h5555);
    bus_write(2'd0, 16'h1234);
    bus_write(2'd2, 16'h0003);
    bus_write(2'd0, 16'hAAAA);
    measure_two("R5 relock by other key", 160);

    // Undefined keys mid-period do not disturb the count; timer keeps running.
    bus_write(2'd0, 16'hAAAA);
    n = 0;
    repeat (50) begin @(negedge clk); n++; end
    bus_write(2'd0, 16'h0000); n += 2;
    bus_write(2'd0, 16'h7777); n += 2;
    bus_write(2'd3, 16'hCCCC); n += 2;
    wait_req(n);
    check("R8 R9 undefined keys", n, 160);

    // Refresh just before expiry restarts the full period.
    bus_write(2'd0, 16'hAAAA);
    repeat (150) @(negedge clk);
    bus_write(2'd0, 16'hAAAA);
    measure_two("R3 late refresh", 160);

    // Reload zero behaves as one; largest division.
    configure(16'h0003, 16'h0000);
    measure_two("R7 reload zero", period_of(3, 0));
    configure(16'h0007, 16'h0001);
    measure_two("R6 divide by 512", 512);

    // Restart key while running keeps it running.
    bus_write(2'd0, 16'hCCCC);
    n = 0;
    wait_req(n);
    check("R8 restart while running", n, 512);

    // Random configurations.
    for (int i = 0; i < 12; i++) begin
      int p;
      int r;
      logic [15:0] pd;
      logic [15:0] rd;
      p  = int'($urandom % 4);
      r  = int'($urandom % 41);
      pd = (16'($urandom) & 16'hFFF8) | 16'(p);
      rd = (16'($urandom) & 16'hF800) | 16'(r);
      configure(pd, rd);
      measure_two("R4 R6 R7 random", period_of(p, r));
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule